// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a computer-operating-properly watchdog. A free-running prescaler counter, `PRE_W` bits wide, produces one tick every time it passes through its all-ones value. Each tick advances a `WDT_W`-bit watchdog counter. When the watchdog counter steps past its maximum value, it wraps and the block raises a reset request for one clock cycle. The chip-level reset controller takes this request and runs the rest of the reset sequence.

Software keeps the watchdog quiet by writing to the all-ones bus address. The data value is never examined, so the block has no data port. Such a write zeroes the watchdog counter. It also zeroes the prescaler bits from `CLR_LO` up to the top bit, while the bits below `CLR_LO` keep counting. For this reason the first tick after a service write comes at least 2^PRE_W − 2^CLR_LO cycles later.

The block has a disable path driven by high-voltage detect flags. In monitor mode, high voltage on either the reset pin or the interrupt pin disables the watchdog. In break mode, only high voltage on the reset pin disables it. This disable is purely combinational from those flags: it stops the counter and masks the request output, and nothing latches it. There is no streaming data: the bus write is a plain one-cycle strobe and every other pin is plain control, so no valid/ready handshake and no back-pressure exist.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` is low, `cop_rst_req` is 0 and both counters are zero. After release with no service and no disable, the first request appears 2^PRE_W · 2^WDT_W clock edges after the first edge with `rst_n` high.
- R2: The watchdog counter advances by one only on an edge where the prescaler holds all ones, so it advances once every 2^PRE_W cycles of free running.
- R3: A tick with the watchdog at all ones wraps the watchdog to zero and drives `cop_rst_req` high for exactly one cycle. Counting then continues, so the next request follows another 2^PRE_W · 2^WDT_W edges later.
- R4: A service write (`bus_wr` high with `bus_addr` all ones) clears the watchdog counter on that edge.
- R5: A service write clears prescaler bits PRE_W−1 down to CLR_LO. Bits CLR_LO−1 down to 0 advance by one as usual.
- R6: A write to any address other than all ones has no effect on either counter or on request timing.
- R7: When a service write and a prescaler tick fall on the same edge, the service wins and the watchdog ends at zero.
- R8: With `mon_mode` high, a high `hv_rst_pin` or a high `hv_irq_pin` disables the watchdog.
- R9: With `brk_mode` high, a high `hv_rst_pin` disables the watchdog. `hv_irq_pin` alone does not disable it, and without either mode neither flag disables it.
- R10: While disabled, the watchdog counter holds its value and `cop_rst_req` is forced low in the same cycle the flags rise, so a pending request is dropped. The prescaler keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Bus write address; all ones is the service address |
| mon_mode | input | 1 | Monitor mode active |
| brk_mode | input | 1 | Break state active |
| hv_rst_pin | input | 1 | High voltage detected on the reset pin |
| hv_irq_pin | input | 1 | High voltage detected on the interrupt pin |
| cop_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The request is registered once after the counting edge. It is visible after the edge on which the final tick lands, and for that one cycle only. The disable mask acts on it with zero cycles of latency. The bench counts clock edges from reset release. A model that follows the requirements steps on each edge using the inputs captured at that edge and queues the edge number of every expected request. A monitor samples on the falling edge and pops the queue, so an early, late, missing or widened pulse is a mismatch at a known edge. Directed checks pin the exact edges: 2048 from reset, 2336 after a service at edge 301, and 2304 after a service that coincides with a tick.

// File: rtl/cop_pkg.sv
package cop_pkg;
  // Combinational disable decode from mode and high-voltage flags.
  function automatic logic cop_off_f(input logic mon, input logic brk,
                                     input logic hvr, input logic hvi);
    return (mon && (hvr || hvi)) || (brk && hvr);
  endfunction
endpackage

// File: rtl/cop_prescaler.sv
module cop_prescaler #(
  parameter int PRE_W  = 13,
  parameter int CLR_LO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc,
  output logic             tick,
  output logic [PRE_W-1:0] pre_q
);
  localparam logic [PRE_W-1:0] KEEP = PRE_W'((1 << CLR_LO) - 1);

  logic [PRE_W-1:0] pre_inc;
  assign pre_inc = pre_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (svc) pre_q <= pre_inc & KEEP;
    else          pre_q <= pre_inc;
  end

  assign tick = &pre_q;

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0)); // R2
  AST_SVC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> ((pre_q & ~KEEP) == '0)); // R5
  AST_SVC_LOW_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (pre_q[CLR_LO-1:0] == CLR_LO'($past(pre_q[CLR_LO-1:0]) + 1'b1))); // R5
endmodule

// File: rtl/cop_counter.sv
module cop_counter #(
  parameter int WDT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc,
  input  logic             adv,
  output logic             ovf_q,
  output logic [WDT_W-1:0] wdt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wdt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (svc) begin
        wdt_q <= '0;
      end else if (adv) begin
        wdt_q <= wdt_q + 1'b1;
        ovf_q <= &wdt_q;
      end
    end
  end

  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (wdt_q == '0)); // R4
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !svc) |=> (wdt_q == WDT_W'($past(wdt_q) + 1'b1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !svc) |=> $stable(wdt_q)); // R10
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q); // R3
  AST_OVF_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (wdt_q == '0)); // R3
endmodule

// File: rtl/cop_disable.sv
module cop_disable
  import cop_pkg::*;
(
  input  logic mon,
  input  logic brk,
  input  logic hvr,
  input  logic hvi,
  output logic off
);
  assign off = cop_off_f(mon, brk, hvr, hvi);

  always_comb begin
    if (!mon && !brk)
      AST_NO_MODE_NO_OFF: assert (!off); // R9
    if (mon && hvi)
      AST_MON_IRQ_OFF: assert (off); // R8
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int PRE_W  = 13,
  parameter int CLR_LO = 4,
  parameter int WDT_W  = 6,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mon_mode,
  input  logic              brk_mode,
  input  logic              hv_rst_pin,
  input  logic              hv_irq_pin,
  output logic              cop_rst_req
);
  localparam logic [ADDR_W-1:0] SVC_ADDR = '1;

  logic             svc, tick, off, ovf_q;
  logic [PRE_W-1:0] pre_q;
  logic [WDT_W-1:0] wdt_q;

  assign svc = bus_wr && (bus_addr == SVC_ADDR);

  cop_prescaler #(.PRE_W(PRE_W), .CLR_LO(CLR_LO)) u_pre (
    .clk(clk), .rst_n(rst_n), .svc(svc), .tick(tick), .pre_q(pre_q)
  );

  cop_disable u_dis (
    .mon(mon_mode), .brk(brk_mode), .hvr(hv_rst_pin), .hvi(hv_irq_pin), .off(off)
  );

  cop_counter #(.WDT_W(WDT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .svc(svc), .adv(tick && !off),
    .ovf_q(ovf_q), .wdt_q(wdt_q)
  );

  assign cop_rst_req = ovf_q && !off;

  AST_SVC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc && tick) |=> (wdt_q == '0)); // R7
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != SVC_ADDR && !tick) |=> $stable(wdt_q)); // R6
  AST_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !svc) |=> (wdt_q == $past(wdt_q))); // R10
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst_req |=> !cop_rst_req); // R3
endmodule

// File: tb/test_cop_watchdog.sv
module test_cop_watchdog;
  localparam int PRE_W = 8, CLR_LO = 4, WDT_W = 3, ADDR_W = 16;
  localparam int PERIOD = (1 << PRE_W) * (1 << WDT_W);

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic mon_mode = 1'b0, brk_mode = 1'b0, hv_rst_pin = 1'b0, hv_irq_pin = 1'b0;
  logic cop_rst_req;

  always #10 clk = ~clk; // 50 MHz

  cop_watchdog #(.PRE_W(PRE_W), .CLR_LO(CLR_LO), .WDT_W(WDT_W), .ADDR_W(ADDR_W)) i_cop_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .mon_mode(mon_mode), .brk_mode(brk_mode), .hv_rst_pin(hv_rst_pin),
    .hv_irq_pin(hv_irq_pin), .cop_rst_req(cop_rst_req)
  );

  int total = 0, bad = 0, cyc = 0, pulses = 0, first_pulse = -1;
  int exp_q[$];
  string tag = "R1";

  // Model state, stepped from the requirements
  int m_pre = 0, m_wdt = 0;
  logic c_rstn, c_svc, c_off;

  function automatic logic off_of(logic m, logic b, logic r, logic i);
    return (m && (r || i)) || (b && r);
  endfunction

  // Capture the inputs as the design sees them at the edge
  always @(posedge clk) begin
    c_rstn = rst_n;
    c_svc  = bus_wr && (bus_addr == '1);
    c_off  = off_of(mon_mode, brk_mode, hv_rst_pin, hv_irq_pin);
  end

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Model (pushes expected requests) and monitor (pops and compares)
  always @(negedge clk) begin
    logic ovf, want;
    ovf = 1'b0;
    if (!c_rstn) begin
      m_pre = 0; m_wdt = 0; cyc = 0;
      exp_q.delete();
    end else begin
      cyc++;
      if (c_svc) m_wdt = 0;
      else if (m_pre == (1 << PRE_W) - 1 && !c_off) begin
        if (m_wdt == (1 << WDT_W) - 1) ovf = 1'b1;
        m_wdt = (m_wdt + 1) % (1 << WDT_W);
      end
      m_pre = (m_pre + 1) % (1 << PRE_W);
      if (c_svc) m_pre = m_pre % (1 << CLR_LO);
      if (ovf && !off_of(mon_mode, brk_mode, hv_rst_pin, hv_irq_pin)) exp_q.push_back(cyc);
      want = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (cop_rst_req === 1'b1) begin
        pulses++;
        if (first_pulse < 0) first_pulse = cyc;
      end
      if (want || cop_rst_req !== 1'b0) begin
        check(tag, want == (cop_rst_req === 1'b1), int'(cop_rst_req), int'(want));
        if (want) void'(exp_q.pop_front());
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    {mon_mode, brk_mode, hv_rst_pin, hv_irq_pin, bus_wr} = '0;
    step(3);
    check("R1", cop_rst_req === 1'b0, int'(cop_rst_req), 0);
    rst_n = 1'b1;
    pulses = 0; first_pulse = -1;
  endtask

  // One-cycle write issued so that it lands on edge number e
  task automatic write_at(input int e, input logic [ADDR_W-1:0] a);
    while (cyc < e - 1) step(1);
    bus_wr = 1'b1; bus_addr = a;
    step(1);
    bus_wr = 1'b0;
  endtask

  task automatic run_to(input int e);
    while (cyc < e) step(1);
  endtask

  initial begin
    do_reset();
    tag = "R1"; run_to(PERIOD + 10);
    check("R1", first_pulse == PERIOD, first_pulse, PERIOD);
    tag = "R3"; run_to(2 * PERIOD + 10);
    check("R3", pulses == 2, pulses, 2);

    do_reset(); tag = "R5";
    write_at(301, '1);
    run_to(2336 + 5);
    check("R5", first_pulse == 2336, first_pulse, 2336);

    do_reset(); tag = "R7";
    write_at(256, '1);
    run_to(2304 + 5);
    check("R7", first_pulse == 2304, first_pulse, 2304);

    do_reset(); tag = "R6";
    write_at(300, 16'h7FFF);
    write_at(700, 16'hFFFE);
    run_to(PERIOD + 5);
    check("R6", first_pulse == PERIOD, first_pulse, PERIOD);

    do_reset(); tag = "R4";
    for (int k = 1; k <= 6; k++) write_at(k * 1500, '1);
    check("R4", pulses == 0, pulses, 0);

    do_reset(); tag = "R8";
    mon_mode = 1'b1; hv_irq_pin = 1'b1; run_to(3000);
    hv_irq_pin = 1'b0; hv_rst_pin = 1'b1; run_to(6000);
    check("R8", pulses == 0, pulses, 0);
    mon_mode = 1'b0; brk_mode = 1'b1; tag = "R9"; run_to(9000);
    check("R9", pulses == 0, pulses, 0);
    hv_rst_pin = 1'b0; hv_irq_pin = 1'b1; run_to(9000 + PERIOD + 300);
    check("R9", pulses == 1, pulses, 1);
    brk_mode = 1'b0; hv_rst_pin = 1'b1; run_to(9000 + 2 * PERIOD + 300);
    check("R9", pulses == 2, pulses, 2);

    do_reset(); tag = "R10";
    run_to(PERIOD - 1);
    @(posedge clk); #2;
    mon_mode = 1'b1; hv_rst_pin = 1'b1;
    @(negedge clk);
    check("R10", cop_rst_req === 1'b0, int'(cop_rst_req), 0);
    #1 {mon_mode, hv_rst_pin} = '0;
    run_to(2 * PERIOD + 5);
    check("R10", pulses == 1 && first_pulse == 2 * PERIOD, first_pulse, 2 * PERIOD);
    check("R3", exp_q.size() == 0, exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired cyc=%0d actual=hung expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule